// File: doc/BRIEF.md
# Reset Sequencer with Source Classification

This block turns any one of several reset requests into a timed reset sequence on a shared, open-drain, active-low reset pin. The requests are power-on, low-voltage, a low level driven onto the pin from outside, an illegal address event, a clock monitor failure and a watchdog timeout. The clock monitor and watchdog requests each have their own enable.

Internal requests pull the pin low and assert the internal reset at once, without waiting for a clock edge. Leaving reset needs the clock. Each request passes through a synchronizer, and the pin is then held low for a fixed count of cycles. The pin is then released. After a further fixed wait, the block reads the pin back and produces a two-bit source code, which the surrounding logic uses to select a reset vector. The internal reset stays asserted until that code is ready.

Top module: `rst_seq`

## Requirements
- R1: Any of power-on, low-voltage, illegal address, a qualified clock monitor failure, a qualified watchdog timeout, or the pin read low while idle starts a sequence. From the first clock edge after it, `int_rst` is 1 and `pin_drive_low` is 1.
- R2: A clock monitor failure is a request only when `clkmon_en` is 1 and `selfclk_en` is 0. Otherwise it leaves `int_rst` and `pin_drive_low` at 0.
- R3: A watchdog timeout is a request only when `wdog_rate` is nonzero. With a rate of 0 it leaves `int_rst` and `pin_drive_low` at 0.
- R4: Entry needs no clock. Without any clock edge, a power-on, low-voltage, illegal address, clock monitor or watchdog request sets `pin_drive_low` and `int_rst` to 1. An external low on the pin sets `int_rst` to 1 but does not drive the pin.
- R5: `pin_drive_low` falls on the clock edge numbered DRIVE_CYC+SYNC_STAGES, counting the edges after the last edge at which any request was seen. With the defaults this is 131 edges. An external pin request counts as seen at only one edge.
- R6: The pin is not driven during the wait. `int_rst` falls on the WAIT_CYC-th edge after the pin is released (64 by default).
- R7: The source code is 0 (power/external class) when the pin reads low at the sampling edge, or when a power-on or low-voltage request was latched during the sequence.
- R8: Otherwise the code is the latched internal source of highest priority: clock monitor = 1, then watchdog = 2, then illegal address = 3. It is 0 when no internal source was latched.
- R9: A request that arrives while the sequence is running restarts the drive phase with its full length. The new source is added to the latched set.
- R10: The latched sources are cleared when a sequence completes, so they have no effect on the code of the next sequence.
- R11: A low level on the pin while a sequence is running is not a request. It neither restarts nor lengthens the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_req | input | 1 | Power-on detected |
| lvd_req | input | 1 | Low voltage detected |
| bad_addr_req | input | 1 | Illegal address access |
| clkmon_fail | input | 1 | Clock monitor reports failure |
| clkmon_en | input | 1 | Clock monitor reset enable |
| selfclk_en | input | 1 | Self-clock mode enable (blocks clock monitor reset) |
| wdog_expired | input | 1 | Watchdog timeout |
| wdog_rate | input | 3 | Watchdog rate field; zero disables its reset |
| pin_in | input | 1 | Value read back from the reset pin |
| pin_drive_low | output | 1 | 1 pulls the reset pin low |
| int_rst | output | 1 | Internal reset to the rest of the chip |
| src_code | output | 2 | Source class of the last completed sequence |

## Verification
The assertions assume that every request lasts across at least one clock edge, because requests are latched only at edges. They also treat power-on as the block's reset, so they are inactive while it is high. The bench holds each request for one to eight edges before releasing it. External low pulses are held either until the sampling edge or until the edge count chosen for release. A power-on sequence is always run before any other stimulus, so every register is loaded before the checks begin.

// File: rtl/rst_seq.sv
module rst_seq #(
  parameter int DRIVE_CYC   = 128,
  parameter int WAIT_CYC    = 64,
  parameter int SYNC_STAGES = 3
) (
  input  logic       clk,
  input  logic       por_req,
  input  logic       lvd_req,
  input  logic       bad_addr_req,
  input  logic       clkmon_fail,
  input  logic       clkmon_en,
  input  logic       selfclk_en,
  input  logic       wdog_expired,
  input  logic [2:0] wdog_rate,
  input  logic       pin_in,
  output logic       pin_drive_low,
  output logic       int_rst,
  output logic [1:0] src_code
);
  localparam int CNT_MAX = (DRIVE_CYC > WAIT_CYC) ? DRIVE_CYC : WAIT_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_DRIVE, PH_WAIT} phase_t;

  phase_t                 ph;
  logic [CW-1:0]          cnt;
  logic [SYNC_STAGES-1:0] sy;
  logic [5:0]             flg;

  logic cm_q, wd_q, ext_q, int_any, req_now, held;
  logic [5:0] raw;
  logic [1:0] cls;

  assign cm_q    = clkmon_fail & clkmon_en & ~selfclk_en;
  assign wd_q    = wdog_expired & (|wdog_rate);
  assign ext_q   = ~pin_in & (ph == PH_IDLE);
  assign int_any = por_req | lvd_req | bad_addr_req | cm_q | wd_q;
  assign req_now = int_any | ext_q;
  assign raw     = {wd_q, cm_q, bad_addr_req, ext_q, lvd_req, por_req};
  assign held    = sy[SYNC_STAGES-1];

  assign pin_drive_low = (ph == PH_DRIVE) | int_any;
  assign int_rst       = (ph != PH_IDLE) | req_now;

  always_comb begin
    if (~pin_in | flg[0] | flg[1]) cls = 2'd0;
    else if (flg[4])               cls = 2'd1;
    else if (flg[5])               cls = 2'd2;
    else if (flg[3])               cls = 2'd3;
    else                           cls = 2'd0;
  end

  always_ff @(posedge clk) begin
    if (req_now) sy <= '1;
    else         sy <= sy << 1;
  end

  always_ff @(posedge clk) begin
    if (req_now) begin
      ph  <= PH_DRIVE;
      cnt <= '0;
      flg <= flg | raw;
    end else begin
      case (ph)
        PH_DRIVE: begin
          if (held) cnt <= '0;
          else if (cnt == CW'(DRIVE_CYC - 1)) begin
            ph  <= PH_WAIT;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        PH_WAIT: begin
          if (cnt == CW'(WAIT_CYC - 1)) begin
            ph       <= PH_IDLE;
            cnt      <= '0;
            flg      <= '0;
            src_code <= cls;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          ph  <= PH_IDLE;
          cnt <= '0;
          flg <= '0;
        end
      endcase
    end
  end
endmodule

module rst_seq_chk (
  input logic       clk,
  input logic       por_req,
  input logic       lvd_req,
  input logic       bad_addr_req,
  input logic       clkmon_fail,
  input logic       clkmon_en,
  input logic       selfclk_en,
  input logic       wdog_expired,
  input logic [2:0] wdog_rate,
  input logic       pin_in,
  input logic       pin_drive_low,
  input logic       int_rst,
  input logic [1:0] src_code
);
  // R4
  entry_drives_pin_chk: assert property (@(posedge clk) disable iff (por_req)
    (lvd_req | bad_addr_req | (clkmon_fail & clkmon_en & ~selfclk_en) |
     (wdog_expired & (|wdog_rate))) |-> (pin_drive_low && int_rst));

  // R6
  drive_within_reset_chk: assert property (@(posedge clk) disable iff (por_req)
    pin_drive_low |-> int_rst);

  // R6
  release_before_exit_chk: assert property (@(posedge clk) disable iff (por_req)
    $fell(pin_drive_low) |-> int_rst);

  // R7
  low_pin_class_chk: assert property (@(posedge clk) disable iff (por_req)
    ($fell(int_rst) && !$past(pin_in)) |-> (src_code == 2'd0));

  // R10
  code_held_idle_chk: assert property (@(posedge clk) disable iff (por_req)
    !int_rst |=> $stable(src_code));
endmodule

bind rst_seq rst_seq_chk u_chk (
  .clk(clk), .por_req(por_req), .lvd_req(lvd_req), .bad_addr_req(bad_addr_req),
  .clkmon_fail(clkmon_fail), .clkmon_en(clkmon_en), .selfclk_en(selfclk_en),
  .wdog_expired(wdog_expired), .wdog_rate(wdog_rate), .pin_in(pin_in),
  .pin_drive_low(pin_drive_low), .int_rst(int_rst), .src_code(src_code)
);

// File: tb/sim_rst_seq.sv
module sim_rst_seq;
  localparam int DRV = 128, WT = 64, SY = 3, SUM = DRV + SY;

  logic clk = 1'b0;
  logic por = 1'b0, lvd = 1'b0, bad = 1'b0, cmf = 1'b0, cme = 1'b0, sce = 1'b0, wdt = 1'b0;
  logic [2:0] wrate = 3'd0;
  logic ext_low = 1'b0;
  logic pin_in, drv, irst;
  logic [1:0] code;
  int total = 0, fails = 0;

  assign pin_in = ~(drv | ext_low);

  always #10 clk = ~clk;

  rst_seq #(.DRIVE_CYC(DRV), .WAIT_CYC(WT), .SYNC_STAGES(SY)) u0 (
    .clk(clk), .por_req(por), .lvd_req(lvd), .bad_addr_req(bad),
    .clkmon_fail(cmf), .clkmon_en(cme), .selfclk_en(sce), .wdog_expired(wdt),
    .wdog_rate(wrate), .pin_in(pin_in), .pin_drive_low(drv), .int_rst(irst),
    .src_code(code));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mask bits: 0 por, 1 lvd, 2 ext, 3 illegal addr, 4 clock monitor, 5 watchdog
  task automatic apply(input logic [5:0] m);
    por = m[0]; lvd = m[1]; ext_low = m[2]; bad = m[3];
    cmf = m[4]; cme = m[4]; sce = 1'b0;
    wdt = m[5]; wrate = m[5] ? 3'($urandom_range(1, 7)) : 3'd0;
  endtask

  task automatic release_int();
    por = 0; lvd = 0; bad = 0; cmf = 0; cme = 0; wdt = 0; wrate = 0;
  endtask

  function automatic int exp_code(input logic [5:0] m, input bit eh);
    if (eh || m[0] || m[1]) return 0;
    if (m[4]) return 1;
    if (m[5]) return 2;
    if (m[3]) return 3;
    return 0;
  endfunction

  task automatic drive_phase(input int exp_n, input int hold, input bit eh);
    int n = 0;
    while (1) begin
      @(posedge clk); n++; @(negedge clk);
      if (n == 1) chk(drv && irst, "R1 entry", {drv, irst}, 3);
      if (n == hold) begin release_int(); if (!eh) ext_low = 0; end
      if (!drv || n > 1000) break;
    end
    chk(n == exp_n, "R5 drive length", n, exp_n);
  endtask

  task automatic wait_phase(input int ecode, input bit eh, input bit poke_ext, input string tag);
    bit ok = 1;
    for (int i = 1; i < WT; i++) begin
      @(posedge clk); @(negedge clk);
      if (!irst || drv) ok = 0;
      if (poke_ext && i == 10) ext_low = 1;
      if (poke_ext && i == 13) ext_low = eh;
    end
    chk(ok, poke_ext ? "R11 pin low in wait" : "R6 wait held", ok, 1);
    @(posedge clk); @(negedge clk);
    chk(irst == eh, "R6 wait length", irst, eh);
    chk(code == 2'(ecode), tag, code, ecode);
    if (eh) begin
      ext_low = 0;
      @(posedge clk); @(negedge clk);
      chk(!irst, "R6 exit", irst, 0);
    end
  endtask

  // poke: 0 none, 1 illegal-address restart in wait, 2 external low in wait
  task automatic run_seq(input logic [5:0] mi, input int hold, input bit eh, input int poke, input string tag);
    logic [5:0] m = eh ? (mi | 6'h04) : mi;
    bit intl = |(m & 6'h3B);
    @(negedge clk);
    apply(m);
    #1;
    if (intl) chk(drv && irst, "R4 async entry", {drv, irst}, 3);
    else      chk(irst && !drv, "R4 ext entry", {drv, irst}, 2);
    drive_phase(intl ? hold + SUM : 1 + SUM, hold, eh);
    if (poke == 1) begin
      repeat (10) @(posedge clk);
      @(negedge clk);
      bad = 1;
      #1 chk(drv && irst, "R9 restart entry", {drv, irst}, 3);
      drive_phase(1 + SUM, 1, eh);
      m = m | 6'h08;
    end
    wait_phase(exp_code(m, eh), eh, poke == 2, tag);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    por = 1;
    #1 chk(drv && irst, "R4 power-on entry", {drv, irst}, 3);
    run_seq(6'h01, 5, 0, 0, "R7 power-on code");

    @(negedge clk); cmf = 1; cme = 1; sce = 1;
    repeat (5) @(posedge clk); @(negedge clk);
    chk(!irst && !drv, "R2 self-clock blocks", {drv, irst}, 0);
    sce = 0; cme = 0;
    repeat (5) @(posedge clk); @(negedge clk);
    chk(!irst && !drv, "R2 disabled monitor", {drv, irst}, 0);
    cmf = 0;
    wdt = 1; wrate = 0;
    repeat (5) @(posedge clk); @(negedge clk);
    chk(!irst && !drv, "R3 rate zero", {drv, irst}, 0);
    wdt = 0;

    run_seq(6'h10, 2, 0, 0, "R8 clock monitor code");
    run_seq(6'h20, 3, 0, 0, "R10 watchdog after monitor");
    run_seq(6'h30, 1, 0, 0, "R8 monitor over watchdog");
    run_seq(6'h28, 4, 0, 0, "R8 watchdog over address");
    run_seq(6'h08, 1, 0, 0, "R8 illegal address code");
    run_seq(6'h12, 2, 0, 0, "R7 low-voltage class");
    run_seq(6'h04, 2, 0, 0, "R7 short external pulse");
    run_seq(6'h20, 2, 1, 0, "R7 pin low at sample");
    run_seq(6'h20, 3, 0, 1, "R9 restart code");
    run_seq(6'h20, 2, 0, 2, "R11 code unchanged");
    run_seq(6'h04, 1, 1, 0, "R7 external held");

    for (int k = 0; k < 40; k++) begin
      logic [5:0] m = 6'($urandom_range(1, 63));
      bit eh = ($urandom_range(0, 3) == 0);
      run_seq(m, $urandom_range(1, 8), eh, 0, "R8 random code");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    chk(0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end
endmodule